// File: doc/BRIEF.md
# Open-Row Memory-Side Prefetcher

This block sits next to a DRAM bank controller and watches one open row at a time. When the controller opens a row, the block clears a per-line record. Each demand access that targets that row marks its line as already fetched. When the controller signals that it is about to close the row, the block walks through the line indices from low to high and offers a prefetch read on a valid/ready channel for every line that no demand has touched. The returned data is meant to be written into the L2 cache, so later accesses to the same row hit there.

Demands for other rows can arrive while the sweep is in progress. A policy input selects how the block responds. Under policy 0, a demand for any other row ends the sweep at once. Under policy 1, the sweep keeps going while the controller's count of waiting demands stays at or below a programmable limit. It is cut short only when that count goes above the limit. When the sweep ends, either complete or cut short, a done flag rises so the controller may close the row. A separate flag shows whether the sweep was cut short. Both flags hold until the next row opens.

The control is a five-state machine. IDLE means no row is known. TRACK means a row is open and demands are being recorded. ISSUE means prefetches are being offered. FINISH means every unfetched line was issued. ABORT means the sweep was stopped early. The transitions are as follows. Open-row moves any state to TRACK. Close-request moves TRACK to ISSUE. In ISSUE, a stop condition moves to ABORT, and no remaining line moves to FINISH.

Top module: `orp_prefetcher`

## Requirements
- R1: While reset is held and in the first cycle after it, pf_valid, pf_done and pf_abort are 0.
- R2: A pulse on row_open clears the line record and latches row_id. In TRACK, a demand whose dem_row equals the latched row marks line dem_line. A demand to any other row marks nothing.
- R3: close_req sampled in TRACK makes pf_valid 1 in the next cycle when at least one line is unmarked. pf_row then equals the latched row.
- R4: Offered lines are exactly the unmarked lines, each offered once, in ascending index order from 0 to LINES-1.
- R5: While pf_valid is 1 and pf_ready is 0, pf_line holds its value unless a same-row demand marks that line. The index advances only when a request is accepted (pf_valid and pf_ready both 1 at a clock edge).
- R6: When no unmarked line remains in ISSUE, the next cycle shows pf_done=1 and pf_abort=0. Both flags then hold until row_open, after which both are 0.
- R7: With policy=0 in ISSUE, a demand with dem_row different from the open row drops pf_valid in the same cycle. The next cycle shows pf_done=1 and pf_abort=1.
- R8: With policy=1, a demand to another row during ISSUE does not stop the sweep while waiting_cnt <= wait_limit.
- R9: With policy=1 in ISSUE, waiting_cnt > wait_limit drops pf_valid at once. The next cycle shows pf_abort=1 and pf_done=1.
- R10: A same-row demand accepted during ISSUE marks its line, so that line is skipped.
- R11: close_req outside TRACK is ignored: pf_valid and pf_done stay 0 in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_open | input | 1 | Pulse: controller opened a new row |
| row_id | input | ROW_W | Row number opened with row_open |
| dem_valid | input | 1 | A demand access is present this cycle |
| dem_row | input | ROW_W | Row of the demand |
| dem_line | input | LIDX_W | Line index of the demand within its row |
| close_req | input | 1 | Controller intends to close the open row |
| policy | input | 1 | 0: demands always win; 1: tolerate waiting demands up to a limit |
| wait_limit | input | WAIT_W | Highest waiting-demand count tolerated under policy 1 |
| waiting_cnt | input | WAIT_W | Number of demands the controller is holding back |
| pf_valid | output | 1 | Prefetch request offered |
| pf_ready | input | 1 | Prefetch request taken |
| pf_row | output | ROW_W | Row of the prefetch (the open row) |
| pf_line | output | LIDX_W | Line index of the prefetch |
| pf_done | output | 1 | Sweep over; the row may be closed |
| pf_abort | output | 1 | Sweep was cut short |

## Verification
The properties assume that dem_line is always below LINES and that every input is at a known level once reset has been released. They also assume the ordering and stability rules only apply outside cycles where row_open or a same-row demand changes the record under the sweep. The stimulus keeps line indices inside the row, opens a row only between sweeps, and holds pf_ready low whenever it injects a same-row demand during a sweep. It then steps through records ranging from empty to full under both policies, and uses several ready patterns to create back-pressure.

// File: rtl/orp_pkg.sv
`timescale 1ns/1ps
package orp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_TRACK  = 3'd1,
        ST_ISSUE  = 3'd2,
        ST_FINISH = 3'd3,
        ST_ABORT  = 3'd4
    } orp_state_e;
endpackage

// File: rtl/orp_line_map.sv
`timescale 1ns/1ps
// Per-line fetched record with two marking ports (demand and accepted prefetch).
module orp_line_map #(
    parameter int LINES  = 16,
    parameter int LIDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              mark_a,
    input  logic [LIDX_W-1:0] idx_a,
    input  logic              mark_b,
    input  logic [LIDX_W-1:0] idx_b,
    output logic [LINES-1:0]  map
);
    for (genvar g = 0; g < LINES; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                map[g] <= 1'b0;
            end else if ((mark_a && (idx_a == LIDX_W'(g))) ||
                         (mark_b && (idx_b == LIDX_W'(g)))) begin
                map[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/orp_gap_finder.sv
`timescale 1ns/1ps
// Lowest-index unmarked line.
module orp_gap_finder #(
    parameter int LINES  = 16,
    parameter int LIDX_W = $clog2(LINES)
) (
    input  logic [LINES-1:0]  map,
    output logic              found,
    output logic [LIDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (!map[i]) begin
                found = 1'b1;
                idx   = LIDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/orp_ctrl.sv
`timescale 1ns/1ps
module orp_ctrl
    import orp_pkg::*;
#(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_open,
    input  logic              close_req,
    input  logic              dem_other,
    input  logic              policy,
    input  logic [WAIT_W-1:0] waiting_cnt,
    input  logic [WAIT_W-1:0] wait_limit,
    input  logic              any_left,
    input  logic              pf_ready,
    output orp_state_e        state,
    output logic              track_en,
    output logic              pf_valid,
    output logic              accept,
    output logic              pf_done,
    output logic              pf_abort
);
    orp_state_e nxt;
    logic       stop_now;

    always_comb begin
        if (policy) stop_now = (waiting_cnt > wait_limit);
        else        stop_now = dem_other;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (row_open) nxt = ST_TRACK;
            ST_TRACK: begin
                if (row_open)       nxt = ST_TRACK;
                else if (close_req) nxt = ST_ISSUE;
            end
            ST_ISSUE: begin
                if (row_open)       nxt = ST_TRACK;
                else if (stop_now)  nxt = ST_ABORT;
                else if (!any_left) nxt = ST_FINISH;
            end
            ST_FINISH: if (row_open) nxt = ST_TRACK;
            ST_ABORT:  if (row_open) nxt = ST_TRACK;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        pf_valid = 1'b0;
        pf_done  = 1'b0;
        pf_abort = 1'b0;
        track_en = 1'b0;
        unique case (state)
            ST_IDLE:   ;
            ST_TRACK:  track_en = 1'b1;
            ST_ISSUE: begin
                track_en = 1'b1;
                pf_valid = any_left && !stop_now && !row_open;
            end
            ST_FINISH: pf_done = 1'b1;
            ST_ABORT: begin
                pf_done  = 1'b1;
                pf_abort = 1'b1;
            end
            default:   ;
        endcase
        accept = pf_valid && pf_ready;
    end
endmodule

// File: rtl/orp_prefetcher.sv
`timescale 1ns/1ps
module orp_prefetcher
    import orp_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int ROW_W  = 14,
    parameter int WAIT_W = 4,
    localparam int LIDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_open,
    input  logic [ROW_W-1:0]  row_id,
    input  logic              dem_valid,
    input  logic [ROW_W-1:0]  dem_row,
    input  logic [LIDX_W-1:0] dem_line,
    input  logic              close_req,
    input  logic              policy,
    input  logic [WAIT_W-1:0] wait_limit,
    input  logic [WAIT_W-1:0] waiting_cnt,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ROW_W-1:0]  pf_row,
    output logic [LIDX_W-1:0] pf_line,
    output logic              pf_done,
    output logic              pf_abort
);
    orp_state_e        state;
    logic [ROW_W-1:0]  cur_row;
    logic [LINES-1:0]  map;
    logic              any_left, track_en, accept, issuing;
    logic              dem_same, dem_other;
    logic [LIDX_W-1:0] gap_idx;

    always_ff @(posedge clk) begin
        if (!rst_n)        cur_row <= '0;
        else if (row_open) cur_row <= row_id;
    end

    assign dem_same  = dem_valid && (dem_row == cur_row);
    assign dem_other = dem_valid && (dem_row != cur_row);
    assign issuing   = (state == ST_ISSUE);

    orp_line_map #(.LINES(LINES), .LIDX_W(LIDX_W)) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (row_open),
        .mark_a (dem_same && track_en),
        .idx_a  (dem_line),
        .mark_b (accept),
        .idx_b  (gap_idx),
        .map    (map)
    );

    orp_gap_finder #(.LINES(LINES), .LIDX_W(LIDX_W)) u_gap (
        .map   (map),
        .found (any_left),
        .idx   (gap_idx)
    );

    orp_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_open    (row_open),
        .close_req   (close_req),
        .dem_other   (dem_other),
        .policy      (policy),
        .waiting_cnt (waiting_cnt),
        .wait_limit  (wait_limit),
        .any_left    (any_left),
        .pf_ready    (pf_ready),
        .state       (state),
        .track_en    (track_en),
        .pf_valid    (pf_valid),
        .accept      (accept),
        .pf_done     (pf_done),
        .pf_abort    (pf_abort)
    );

    assign pf_row  = cur_row;
    assign pf_line = gap_idx;
endmodule

// File: rtl/orp_checker.sv
`timescale 1ns/1ps
module orp_checker #(
    parameter int ROW_W  = 14,
    parameter int LIDX_W = 4,
    parameter int WAIT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              row_open,
    input logic              dem_valid,
    input logic [ROW_W-1:0]  dem_row,
    input logic              policy,
    input logic [WAIT_W-1:0] waiting_cnt,
    input logic [WAIT_W-1:0] wait_limit,
    input logic              issuing,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ROW_W-1:0]  pf_row,
    input logic [LIDX_W-1:0] pf_line,
    input logic              pf_done,
    input logic              pf_abort
);
    assert_line_ascends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && pf_ready && !row_open) |=> (!pf_valid || (pf_line > $past(pf_line))));

    assert_line_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready && !row_open && !(dem_valid && dem_row == pf_row))
        |=> (!pf_valid || $stable(pf_line)));

    assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_done && !row_open) |=> pf_done);

    assert_open_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        row_open |=> (!pf_done && !pf_abort));

    assert_quiet_when_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pf_done |-> !pf_valid);

    assert_abort_is_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pf_abort |-> pf_done);

    assert_demand_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (issuing && !policy && dem_valid && dem_row != pf_row && !row_open) |=> pf_abort);

    assert_queue_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issuing && policy && (waiting_cnt > wait_limit) && !row_open) |=> pf_abort);
endmodule

bind orp_prefetcher orp_checker #(.ROW_W(ROW_W), .LIDX_W(LIDX_W), .WAIT_W(WAIT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .row_open(row_open), .dem_valid(dem_valid),
    .dem_row(dem_row), .policy(policy), .waiting_cnt(waiting_cnt),
    .wait_limit(wait_limit), .issuing(issuing), .pf_valid(pf_valid),
    .pf_ready(pf_ready), .pf_row(pf_row), .pf_line(pf_line),
    .pf_done(pf_done), .pf_abort(pf_abort)
);

// File: tb/sim_orp_prefetcher.sv
`timescale 1ns/1ps
module sim_orp_prefetcher;
    localparam int LINES = 16;
    localparam int ROW_W = 14;
    localparam int WAIT_W = 4;
    // fields: [20:5] lines demanded before close, [4] policy, [3:0] ready pattern
    localparam logic [20:0] VECS [6] = '{
        {16'h0000, 1'b0, 4'b1111},
        {16'hA5A5, 1'b1, 4'b1010},
        {16'hFFFE, 1'b0, 4'b0011},
        {16'h7FFF, 1'b1, 4'b1111},
        {16'hFFFF, 1'b0, 4'b1111},
        {16'h0F0F, 1'b1, 4'b0101}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, row_open, dem_valid, close_req, policy, pf_ready;
    logic [ROW_W-1:0] row_id, dem_row, pf_row;
    logic [3:0] dem_line, pf_line;
    logic [WAIT_W-1:0] wait_limit, waiting_cnt;
    logic pf_valid, pf_done, pf_abort;

    int checks = 0;
    int fails = 0;
    int got [LINES];
    int n_got;

    orp_prefetcher #(.LINES(LINES), .ROW_W(ROW_W), .WAIT_W(WAIT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .row_open(row_open), .row_id(row_id),
        .dem_valid(dem_valid), .dem_row(dem_row), .dem_line(dem_line),
        .close_req(close_req), .policy(policy), .wait_limit(wait_limit),
        .waiting_cnt(waiting_cnt), .pf_valid(pf_valid), .pf_ready(pf_ready),
        .pf_row(pf_row), .pf_line(pf_line), .pf_done(pf_done), .pf_abort(pf_abort)
    );

    task automatic chk(input string req, input logic ok, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic open_row(input int id);
        row_open = 1'b1; row_id = ROW_W'(id);
        tick();
        row_open = 1'b0;
    endtask

    task automatic demand(input int row, input int line);
        dem_valid = 1'b1; dem_row = ROW_W'(row); dem_line = 4'(line);
        tick();
        dem_valid = 1'b0;
    endtask

    task automatic close_row();
        close_req = 1'b1;
        tick();
        close_req = 1'b0;
    endtask

    task automatic collect(input logic [3:0] pat);
        n_got = 0;
        for (int k = 0; k < 64; k++) begin
            if (pf_done) break;
            pf_ready = pat[k % 4];
            #1;
            if (pf_valid && pf_ready && n_got < LINES) begin
                got[n_got] = int'(pf_line);
                n_got++;
            end
            tick();
        end
        pf_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; row_open = 1'b0; row_id = '0; dem_valid = 1'b0; dem_row = '0;
        dem_line = '0; close_req = 1'b0; policy = 1'b0; pf_ready = 1'b0;
        wait_limit = 4'd2; waiting_cnt = '0;
        repeat (3) tick();
        chk("R1 outputs in reset", !pf_valid && !pf_done && !pf_abort,
            {pf_valid, pf_done, pf_abort}, 0);
        rst_n = 1'b1;
        tick();
        chk("R1 outputs after reset", !pf_valid && !pf_done && !pf_abort,
            {pf_valid, pf_done, pf_abort}, 0);

        // R11: close request with no row open
        close_row();
        chk("R11 no prefetch in IDLE", !pf_valid && !pf_done, {pf_valid, pf_done}, 0);
        tick();
        chk("R11 still quiet", !pf_valid && !pf_done, {pf_valid, pf_done}, 0);

        // R2/R3/R5/R10/R7 directed sequence, policy 0
        open_row(5);
        demand(5, 3);
        demand(9, 0);       // other row: must not mark line 0
        close_row();
        chk("R3 valid after close", pf_valid, pf_valid, 1);
        chk("R2 other-row demand ignored", pf_line == 0, pf_line, 0);
        chk("R3 prefetch row", pf_row == 14'd5, pf_row, 5);
        tick();
        chk("R5 line held without ready", pf_valid && pf_line == 0, pf_line, 0);
        pf_ready = 1'b1;
        tick();
        chk("R5 advance on accept", pf_line == 1, pf_line, 1);
        tick();
        chk("R4 next line", pf_line == 2, pf_line, 2);
        pf_ready = 1'b0;
        demand(5, 4);
        chk("R5 held during demand to other line", pf_line == 2, pf_line, 2);
        pf_ready = 1'b1;
        tick();
        chk("R10 skips demanded lines 3 and 4", pf_line == 5, pf_line, 5);
        pf_ready = 1'b0;
        dem_valid = 1'b1; dem_row = 14'd9; dem_line = 4'd7;
        #1;
        chk("R7 valid drops with other-row demand", !pf_valid, pf_valid, 0);
        tick();
        dem_valid = 1'b0;
        chk("R7 abort flagged", pf_abort && pf_done, {pf_abort, pf_done}, 3);
        tick(); tick();
        chk("R6 abort holds", pf_abort && pf_done && !pf_valid, {pf_abort, pf_done}, 3);
        open_row(6);
        chk("R6 flags clear on new row", !pf_abort && !pf_done, {pf_abort, pf_done}, 0);

        // R8/R9 policy 1
        policy = 1'b1; wait_limit = 4'd2;
        open_row(7);
        close_row();
        dem_valid = 1'b1; dem_row = 14'd9; dem_line = 4'd2; waiting_cnt = 4'd2;
        tick();
        dem_valid = 1'b0;
        chk("R8 sweep continues at limit", !pf_abort && pf_valid && pf_line == 0,
            pf_abort, 0);
        waiting_cnt = 4'd3;
        tick();
        chk("R9 abort above limit", pf_abort && pf_done, pf_abort, 1);
        waiting_cnt = 4'd0;

        // table walk: R2, R4, R6
        for (int v = 0; v < 6; v++) begin
            logic [15:0] mask;
            logic ok;
            int n_exp;
            mask = VECS[v][20:5];
            policy = VECS[v][4];
            open_row(100 + v);
            for (int i = 0; i < LINES; i++) if (mask[i]) demand(100 + v, i);
            close_row();
            collect(VECS[v][3:0]);
            n_exp = 0; ok = 1'b1;
            for (int i = 0; i < LINES; i++) begin
                if (!mask[i]) begin
                    if (n_exp >= n_got || got[n_exp] != i) ok = 1'b0;
                    n_exp++;
                end
            end
            chk("R4 prefetch count", n_got == n_exp, n_got, n_exp);
            chk("R2 R4 prefetch order", ok, v, v);
            chk("R6 done without abort", pf_done && !pf_abort, {pf_done, pf_abort}, 2);
            tick(); tick();
            chk("R6 done holds", pf_done && !pf_valid, pf_done, 1);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule